// File: doc/BRIEF.md
# Pin Interrupt Detection Unit

This block watches 32 general-purpose input pins and turns their activity into pending interrupt bits and one combined interrupt request for a cascaded interrupt controller. The pins form two halves of 16 (pins 0–15 and 16–31), and every control or status word holds one bit per pin of its half. Each pin is first brought into the clock domain by a two-flop synchroniser. It is then judged either by level, with a selectable active polarity, or by edge, with separate enables for the rising and the falling transition.

A per-pin latch select decides how the pending bit behaves. With the latch on, an event sets the bit and the bit stays set until software writes a 1 to it. With the latch off, the pending bit simply mirrors the detected condition, one cycle behind it. Pending bits are recorded whatever the mask says. The mask only gates which pending bits reach the combined request.

Software reaches the unit over a plain 16-bit register bus with a write strobe and a combinational read port. The per-half words sit at fixed byte offsets, because interrupt service code decodes them. The low half of each pair is at the base offset and the high half at base + 2.

Top module: `pin_irq_unit`

## Requirements
- R1: While reset is held, and until the first input activity after it, every mask and configuration word reads 0, and the combined request `irq_o` is 0.
- R2: The bus words read back what was written: mask at 0x0C/0x0E, trigger kind at 0x10/0x12, polarity at 0x14/0x16, latch select at 0x18/0x1A, falling-edge enable at 0x20/0x22 and rising-edge enable at 0x24/0x26 (low half/high half). An address that maps to no word reads 0.
- R3: With kind bit 0 (level), a pin is active when its synchronised value equals its polarity bit (1 = active high, 0 = active low). A pin change applied before clock edge k shows in the pending word at 0x08/0x0A after edge k+2.
- R4: With kind bit 1 (edge), a 0→1 transition is an event only if the rising enable is set, and a 1→0 transition only if the falling enable is set. With both set, either transition is an event. With neither set, no event is seen, and a pin that holds steady never produces an edge event.
- R5: With latch bit 1, a pending bit stays set after the condition goes away. Writing 1 to that bit of the pending word clears it, and writing 0 leaves it set.
- R6: With latch bit 0, the pending bit follows the detected condition. For an edge this is a pulse exactly one cycle long, and a write-1-to-clear has no lasting effect.
- R7: `irq_o` is 1 exactly when some pin of either half has both its pending bit and its mask bit set. Pending bits are recorded for masked pins while `irq_o` stays 0.
- R8: When a new event and a write-1-to-clear hit the same pending bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 32 | Raw pin levels, bit n = pin n |
| bus_wr_i | input | 1 | Write strobe, one word per cycle |
| bus_addr_i | input | 6 | Byte address of the word |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The clear path and the detection path can land on one pending bit in the same clock: a write-1-to-clear to the pending word and a fresh edge from the synchroniser. The bench first sets a latched rising-edge pin. It then raises the pin again and times the clearing write so that the write is sampled on the very edge where the new rising event reaches the pending register, which is two edges after the pin change. It judges the result by reading the pending word afterwards: the bit must still be 1. A second, event-free clear must then bring it to 0, which shows the clear itself was working.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int REG_W      = 16;
  localparam int ADDR_W     = 6;
  localparam int NUM_CFG    = 6;
  localparam int HALF_STEP  = 2;

  // byte offsets of the low-half word; high half sits HALF_STEP above
  localparam logic [ADDR_W-1:0] OFS_PEND  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_KIND  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_POL   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_LATCH = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_FALL  = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_RISE  = 6'h24;

  // index order of the configuration word array
  localparam int IDX_MASK  = 0;
  localparam int IDX_KIND  = 1;
  localparam int IDX_POL   = 2;
  localparam int IDX_LATCH = 3;
  localparam int IDX_FALL  = 4;
  localparam int IDX_RISE  = 5;

  localparam logic [ADDR_W-1:0] CFG_BASE [NUM_CFG] =
    '{OFS_MASK, OFS_KIND, OFS_POL, OFS_LATCH, OFS_FALL, OFS_RISE};

  typedef logic [REG_W-1:0] word_t;

  typedef struct packed {
    word_t mask;
    word_t kind;
    word_t pol;
    word_t latch;
    word_t fall;
    word_t rise;
  } half_cfg_t;

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                  input int unsigned half);
    return base + ADDR_W'(HALF_STEP * half);
  endfunction

  function automatic word_t edge_hits(input word_t cur, input word_t prev,
                                      input word_t fall_en, input word_t rise_en);
    return (cur & ~prev & rise_en) | (~cur & prev & fall_en);
  endfunction

  function automatic word_t level_hits(input word_t cur, input word_t pol);
    return ~(cur ^ pol);
  endfunction

  function automatic word_t pick_detect(input word_t kind, input word_t edges,
                                        input word_t levels);
    return (kind & edges) | (~kind & levels);
  endfunction

  function automatic word_t pend_next(input word_t pend, input word_t det,
                                      input word_t latch, input word_t clr);
    return (latch & ((pend & ~clr) | det)) | (~latch & det);
  endfunction

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync
  import pin_irq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;

  // R3: the delayed copy is always the synchronised value of one cycle before
  p_prev_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev_q == $past(sync_q)));

endmodule

// File: rtl/pin_irq_cfg.sv
module pin_irq_cfg
  import pin_irq_pkg::*;
#(
  parameter int HALF = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wdata_i,
  input  word_t             pend_i,
  output half_cfg_t         cfg_o,
  output word_t             clr_o,
  output word_t             rdata_o
);

  localparam logic [ADDR_W-1:0] PEND_ADDR = word_addr(OFS_PEND, HALF);

  word_t cfg_q [NUM_CFG];
  logic  hit   [NUM_CFG];

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_word
    localparam logic [ADDR_W-1:0] MY_ADDR = word_addr(CFG_BASE[k], HALF);
    assign hit[k] = (addr_i == MY_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cfg_q[k] <= '0;
      else if (wr_i && hit[k]) cfg_q[k] <= wdata_i;
    end
  end

  assign cfg_o.mask  = cfg_q[IDX_MASK];
  assign cfg_o.kind  = cfg_q[IDX_KIND];
  assign cfg_o.pol   = cfg_q[IDX_POL];
  assign cfg_o.latch = cfg_q[IDX_LATCH];
  assign cfg_o.fall  = cfg_q[IDX_FALL];
  assign cfg_o.rise  = cfg_q[IDX_RISE];

  assign clr_o = (wr_i && addr_i == PEND_ADDR) ? wdata_i : '0;

  always_comb begin
    rdata_o = (addr_i == PEND_ADDR) ? pend_i : '0;
    for (int k = 0; k < NUM_CFG; k++) begin
      if (hit[k]) rdata_o = cfg_q[k];
    end
  end

  // R2: a write to the mask word is visible in the mask field next cycle
  p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && hit[IDX_MASK]) |=> (cfg_o.mask == $past(wdata_i)));

  // R2: with no write strobe the configuration stays put
  p_cfg_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(cfg_o));

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  word_t     sync_i,
  input  word_t     prev_i,
  input  half_cfg_t cfg_i,
  input  word_t     clr_i,
  output word_t     pend_o,
  output word_t     edge_o,
  output word_t     det_o
);

  word_t level_w;
  word_t pend_q;

  assign edge_o  = edge_hits(sync_i, prev_i, cfg_i.fall, cfg_i.rise);
  assign level_w = level_hits(sync_i, cfg_i.pol);
  assign det_o   = pick_detect(cfg_i.kind, edge_o, level_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_next(pend_q, det_o, cfg_i.latch, clr_i);
  end

  assign pend_o = pend_q;

  // R4: a pin whose synchronised value did not move yields no edge event
  p_still_no_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_o & ~(sync_i ^ prev_i)) == '0));

  // R5: latched, uncleared bits survive into the next cycle
  p_latch_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & cfg_i.latch & ~clr_i))
              == $past(pend_q & cfg_i.latch & ~clr_i)));

  // R8: an event coinciding with a clear leaves the bit set
  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(det_o & clr_i)) == $past(det_o & clr_i)));

endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pin_irq_pkg::*;
#(
  parameter int NUM_HALVES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_HALVES*REG_W-1:0] pins_i,
  input  logic                        bus_wr_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [REG_W-1:0]            bus_wdata_i,
  output logic [REG_W-1:0]            bus_rdata_o,
  output logic                        irq_o
);

  localparam int NUM_PINS = NUM_HALVES * REG_W;

  word_t     sync_w  [NUM_HALVES];
  word_t     prev_w  [NUM_HALVES];
  word_t     pend_w  [NUM_HALVES];
  word_t     edge_w  [NUM_HALVES];
  word_t     det_w   [NUM_HALVES];
  word_t     clr_w   [NUM_HALVES];
  word_t     rdata_w [NUM_HALVES];
  half_cfg_t cfg_w   [NUM_HALVES];

  logic [NUM_PINS-1:0] pend_all;
  logic [NUM_PINS-1:0] mask_all;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    pin_irq_sync #(.W(REG_W)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pins_i[h*REG_W +: REG_W]),
      .sync_o (sync_w[h]),
      .prev_o (prev_w[h])
    );

    pin_irq_cfg #(.HALF(h)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (bus_wr_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .pend_i  (pend_w[h]),
      .cfg_o   (cfg_w[h]),
      .clr_o   (clr_w[h]),
      .rdata_o (rdata_w[h])
    );

    pin_irq_detect u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (sync_w[h]),
      .prev_i (prev_w[h]),
      .cfg_i  (cfg_w[h]),
      .clr_i  (clr_w[h]),
      .pend_o (pend_w[h]),
      .edge_o (edge_w[h]),
      .det_o  (det_w[h])
    );

    assign pend_all[h*REG_W +: REG_W] = pend_w[h];
    assign mask_all[h*REG_W +: REG_W] = cfg_w[h].mask;
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int h = 0; h < NUM_HALVES; h++) bus_rdata_o |= rdata_w[h];
  end

  assign irq_o = |(pend_all & mask_all);

  // R7: with every mask bit clear the request stays low
  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_all == '0) |-> !irq_o);

  // R7: a request implies some pending bit exists
  p_req_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_all != '0));

endmodule

// File: tb/pin_irq_unit_tb.sv
`timescale 1ns/1ps
module pin_irq_unit_tb;

  localparam real HALF_PER = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(HALF_PER) clk = ~clk;

  pin_irq_unit u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_i      (pins),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  // vector: pin[11:7] kind[6] pol[5] latch[4] fall[3] rise[2] before[1] after[0]
  localparam logic [11:0] VEC [14] = '{
    {5'd3,  7'b0100001}, {5'd3,  7'b0100010}, {5'd5,  7'b0000010},
    {5'd20, 7'b0010001}, {5'd20, 7'b0110000}, {5'd7,  7'b1010101},
    {5'd7,  7'b1010110}, {5'd22, 7'b1011010}, {5'd22, 7'b1011001},
    {5'd31, 7'b1011101}, {5'd31, 7'b1011110}, {5'd0,  7'b1010001},
    {5'd15, 7'b1000101}, {5'd16, 7'b1001110}
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr_word(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_word(input logic [5:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [5:0] hofs(input logic [5:0] base, input int pin);
    return base + ((pin >= 16) ? 6'd2 : 6'd0);
  endfunction

  task automatic cfg_pin(input int pin, input bit kind, input bit pol, input bit latch,
                         input bit fall, input bit rise, input bit en);
    logic [15:0] m;
    m = 16'h1 << (pin % 16);
    wr_word(hofs(6'h10, pin), kind  ? m : 16'h0);
    wr_word(hofs(6'h14, pin), pol   ? m : 16'h0);
    wr_word(hofs(6'h18, pin), latch ? m : 16'h0);
    wr_word(hofs(6'h20, pin), fall  ? m : 16'h0);
    wr_word(hofs(6'h24, pin), rise  ? m : 16'h0);
    wr_word(hofs(6'h0C, pin), en    ? m : 16'h0);
    wr_word((pin >= 16) ? 6'h0C : 6'h0E, 16'h0);
  endtask

  function automatic bit expect_pend(input logic [11:0] v);
    bit kind, pol, latch, fall, rise, b, a;
    {kind, pol, latch, fall, rise, b, a} = v[6:0];
    if (kind) return (rise && !b && a) || (fall && b && !a);
    if (latch) return (b == pol) || (a == pol);
    return a == pol;
  endfunction

  function automatic string vec_req(input logic [11:0] v);
    if (!v[6]) return v[4] ? "R3/R5" : "R3";
    return v[4] ? "R4" : "R4/R6";
  endfunction

  initial begin : watchdog
    #(HALF_PER * 2 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    int p;
    // R1: reset state
    repeat (3) @(negedge clk);
    rd_word(6'h0C, d); check("R1 mask lo", d, 0);
    rd_word(6'h12, d); check("R1 kind hi", d, 0);
    rd_word(6'h08, d); check("R1 pending lo", d, 0);
    check("R1 irq", irq, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: write and read back every word of both halves
    for (int k = 0; k < 12; k++) begin
      logic [5:0] a;
      a = (k < 2) ? 6'h0C + 6'(2*k) : (k < 8) ? 6'h10 + 6'(2*(k-2)) : 6'h20 + 6'(2*(k-8));
      wr_word(a, 16'hA5C3 ^ 16'(k * 16'h1111));
      rd_word(a, d);
      check("R2 readback", d, 16'hA5C3 ^ 16'(k * 16'h1111));
    end
    rd_word(6'h02, d); check("R2 unmapped", d, 0);
    wr_word(6'h0C, 16'h0); wr_word(6'h0E, 16'h0);

    // vector table
    for (int i = 0; i < 14; i++) begin
      logic [11:0] v;
      v = VEC[i];
      p = int'(v[11:7]);
      pins = '0;
      pins[p] = v[1];
      cfg_pin(p, v[6], v[5], v[4], v[3], v[2], 1'b1);
      repeat (2) @(negedge clk);
      wr_word(hofs(6'h08, p), 16'h1 << (p % 16));
      pins[p] = v[0];
      repeat (3) @(negedge clk);
      rd_word(hofs(6'h08, p), d);
      check(vec_req(v), d[p % 16], expect_pend(v));
      check("R7 vector irq", irq, expect_pend(v));
    end

    // R6: non-latched edge lasts one cycle
    pins = '0;
    cfg_pin(9, 1, 0, 0, 0, 1, 0);
    repeat (3) @(negedge clk);
    pins[9] = 1'b1;
    repeat (3) @(negedge clk);
    rd_word(6'h08, d); check("R6 pulse on", d[9], 1);
    @(negedge clk);
    rd_word(6'h08, d); check("R6 pulse off", d[9], 0);

    // R5: latched falling edge holds, zero write ignored, one write clears
    pins = '0; pins[18] = 1'b1;
    cfg_pin(18, 1, 0, 1, 1, 0, 0);
    repeat (3) @(negedge clk);
    wr_word(6'h0A, 16'h0004);
    pins[18] = 1'b0;
    repeat (8) @(negedge clk);
    rd_word(6'h0A, d); check("R5 held", d[2], 1);
    wr_word(6'h0A, 16'hFFFB);
    rd_word(6'h0A, d); check("R5 zero write", d[2], 1);
    wr_word(6'h0A, 16'h0004);
    rd_word(6'h0A, d); check("R5 cleared", d[2], 0);

    // R7: masked pins record status; mask drives irq, in each half
    pins = '0; pins[2] = 1'b1;
    cfg_pin(2, 0, 1, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    rd_word(6'h08, d); check("R7 recorded masked", d[2], 1);
    check("R7 masked irq", irq, 0);
    wr_word(6'h0C, 16'h0004);
    #1; check("R7 unmasked irq", irq, 1);
    pins = '0; pins[25] = 1'b1;
    cfg_pin(25, 0, 1, 0, 0, 0, 1);
    repeat (4) @(negedge clk);
    #1; check("R7 high half irq", irq, 1);
    pins[25] = 1'b0;
    repeat (3) @(negedge clk);
    #1; check("R7 irq drops", irq, 0);

    // R8: event and clear in the same cycle
    pins = '0;
    cfg_pin(4, 1, 0, 1, 0, 1, 1);
    repeat (3) @(negedge clk);
    wr_word(6'h08, 16'h0010);
    pins[4] = 1'b1;
    repeat (3) @(negedge clk);
    pins[4] = 1'b0;
    repeat (4) @(negedge clk);
    rd_word(6'h08, d); check("R8 first event", d[4], 1);
    pins[4] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr = 1'b1; addr = 6'h08; wdata = 16'h0010;
    @(negedge clk);
    wr = 1'b0;
    rd_word(6'h08, d); check("R8 event wins", d[4], 1);
    wr_word(6'h08, 16'h0010);
    rd_word(6'h08, d); check("R8 later clear", d[4], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule